// File: doc/BRIEF.md
# Double-Precision Predicate Mask Comparator

This block compares two IEEE-754 double-precision operands under one of eight predicates chosen by a 3-bit code. When the predicate holds, the result is a 64-bit mask of all ones. When it does not hold, the result is all zeros. Downstream logic can then AND the mask with data to make a branch-free select.

The block classifies each operand as NaN, zero or an ordinary value. It works out three relations from sign-magnitude ordering: equal, less than and unordered. The predicate code picks one of eight functions of these relations. The mask and its valid strobe are registered, so a result appears one cycle after its operands are presented. Positive and negative zero are treated as the same value. Exception flags are not produced.

Top module: `fp_pred_cmp`

## Requirements
- R1: Code 0 (equal) is true only when neither operand is NaN and the values are equal; NaN against NaN is false.
- R2: Code 1 (A < B) and code 2 (A <= B) are false whenever either operand is NaN.
- R3: Code 3 (unordered) is true exactly when at least one operand is NaN.
- R4: Code 4 (not equal) is true for unequal values and whenever a NaN is present; it is false for equal values, including +inf against +inf.
- R5: Code 5 (not A < B) and code 6 (not A <= B) are true whenever a NaN is present; for ordered operands they are the inverse of codes 1 and 2.
- R6: Code 7 (ordered) is true exactly when neither operand is NaN.
- R7: A true result gives mask 0xFFFFFFFFFFFFFFFF and a false result gives 0x0. No other mask value occurs.
- R8: Infinities order by sign: -inf is less than every finite value, every finite value is less than +inf, and an infinity equals itself.
- R9: +0 and -0 compare as equal under every predicate.
- R10: Mask and valid are registered. out_vld is in_vld delayed one cycle, and the mask is sampled with the same delay. After reset, out_vld is 0 and the mask is 0.
- R11: A NaN is any operand with exponent field all ones (bits 62:52) and a nonzero fraction (bits 51:0). Bit 63 is the sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_vld | input | 1 | Operands and code are valid |
| op_a | input | 64 | Operand A, double precision |
| op_b | input | 64 | Operand B, double precision |
| pred | input | 3 | Predicate code 0..7 |
| out_vld | output | 1 | Result valid, one cycle after in_vld |
| mask | output | 64 | All-ones or all-zeros result mask |

## Verification
Each comparison resolves into a single bit that is then spread over 64 bits. A corrupted relation or a wrong predicate decode therefore shows up as a fully inverted mask on the very next cycle. A broken register shows up as a mask that is neither all ones nor all zeros. A valid pipeline fault makes out_vld lose its one-cycle alignment with in_vld, which is visible on the first strobe. The NaN and signed-zero operands are the stimulus most likely to expose a misclassified operand. Each such error appears at the ports one clock after the offending input.

// File: rtl/fp_pred_cmp_pkg.sv
package fp_pred_cmp_pkg;
    localparam int FP_W   = 64;
    localparam int EXP_W  = 11;
    localparam int FRAC_W = 52;
    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        P_EQ    = 3'd0,
        P_LT    = 3'd1,
        P_LE    = 3'd2,
        P_UNORD = 3'd3,
        P_NE    = 3'd4,
        P_NLT   = 3'd5,
        P_NLE   = 3'd6,
        P_ORD   = 3'd7
    } pred_e;

    typedef struct packed {
        logic is_nan;
        logic is_zero;
        logic sign;
        logic [FP_W-2:0] mag;
    } opnd_t;

    typedef struct packed {
        logic eq;
        logic lt;
        logic un;
    } rel_t;

    typedef struct packed {
        logic            vld;
        logic [FP_W-1:0] mask;
    } out_t;
endpackage

// File: rtl/fp_opnd_class.sv
module fp_opnd_class
    import fp_pred_cmp_pkg::*;
#(
    parameter int W  = FP_W,
    parameter int EW = EXP_W,
    parameter int FW = FRAC_W
) (
    input  logic [W-1:0] val,
    output opnd_t        cls
);
    localparam int EXP_LO = FW;
    localparam int EXP_HI = FW + EW - 1;

    logic exp_ones;
    logic frac_nz;

    always_comb begin
        exp_ones    = &val[EXP_HI:EXP_LO];
        frac_nz     = |val[FW-1:0];
        cls.is_nan  = exp_ones & frac_nz;
        cls.is_zero = ~|val[W-2:0];
        cls.sign    = val[W-1];
        cls.mag     = val[W-2:0];
    end
endmodule

// File: rtl/fp_rel_core.sv
module fp_rel_core
    import fp_pred_cmp_pkg::*;
(
    input  opnd_t a,
    input  opnd_t b,
    output rel_t  rel
);
    logic both_zero;
    logic mag_lt;
    logic mag_eq;
    logic ord_lt;

    always_comb begin
        both_zero = a.is_zero & b.is_zero;
        mag_lt    = a.mag < b.mag;
        mag_eq    = a.mag == b.mag;
        if (both_zero)
            ord_lt = 1'b0;
        else if (a.sign != b.sign)
            ord_lt = a.sign;
        else if (a.sign)
            ord_lt = ~mag_lt & ~mag_eq;
        else
            ord_lt = mag_lt;

        rel.un = a.is_nan | b.is_nan;
        rel.eq = ~rel.un & (both_zero | (mag_eq & (a.sign == b.sign)));
        rel.lt = ~rel.un & ord_lt;
    end
endmodule

// File: rtl/fp_pred_cmp.sv
module fp_pred_cmp
    import fp_pred_cmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [FP_W-1:0]   op_a,
    input  logic [FP_W-1:0]   op_b,
    input  logic [CODE_W-1:0] pred,
    output logic              out_vld,
    output logic [FP_W-1:0]   mask
);
    opnd_t cls_a, cls_b;
    rel_t  rel;
    logic  hit;
    out_t  st_d, st_q;

    fp_opnd_class u_cls_a (.val(op_a), .cls(cls_a));
    fp_opnd_class u_cls_b (.val(op_b), .cls(cls_b));
    fp_rel_core   u_rel   (.a(cls_a), .b(cls_b), .rel(rel));

    always_comb begin
        unique case (pred_e'(pred))
            P_EQ:    hit = rel.eq;
            P_LT:    hit = rel.lt;
            P_LE:    hit = rel.lt | rel.eq;
            P_UNORD: hit = rel.un;
            P_NE:    hit = ~rel.eq;
            P_NLT:   hit = ~rel.lt;
            P_NLE:   hit = ~(rel.lt | rel.eq);
            P_ORD:   hit = ~rel.un;
            default: hit = 1'b0;
        endcase
        st_d.vld  = in_vld;
        st_d.mask = {FP_W{hit}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld = st_q.vld;
    assign mask    = st_q.mask;
endmodule

// File: rtl/fp_pred_cmp_chk.sv
module fp_pred_cmp_chk
    import fp_pred_cmp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_vld,
    input logic [FP_W-1:0]   op_a,
    input logic [FP_W-1:0]   op_b,
    input logic [CODE_W-1:0] pred,
    input logic              out_vld,
    input logic [FP_W-1:0]   mask
);
    function automatic logic nan_f(input logic [FP_W-1:0] v);
        return (&v[62:52]) & (|v[51:0]);
    endfunction

    AST_MASK_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) || (mask == '1)); // R7
    AST_VLD_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 out_vld == $past(in_vld)); // R10
    AST_UNORD_NAN: assert property (@(posedge clk) disable iff (!rst_n)
        (pred == 3'd3) |=> (mask[0] == (nan_f($past(op_a)) | nan_f($past(op_b))))); // R3
    AST_ORD_NAN: assert property (@(posedge clk) disable iff (!rst_n)
        (pred == 3'd7) |=> (mask[0] == ~(nan_f($past(op_a)) | nan_f($past(op_b))))); // R6
    AST_EQ_NAN_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
        (pred == 3'd0 && (nan_f(op_a) || nan_f(op_b))) |=> (mask == '0)); // R1
    AST_NE_NAN_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
        (pred == 3'd4 && (nan_f(op_a) || nan_f(op_b))) |=> (mask == '1)); // R4
endmodule

bind fp_pred_cmp fp_pred_cmp_chk u_chk (.*);

// File: tb/sim_fp_pred_cmp.sv
module sim_fp_pred_cmp;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [63:0] op_a = '0, op_b = '0;
    logic [2:0]  pred = '0;
    logic        out_vld;
    logic [63:0] mask;
    int n_run = 0, n_fail = 0;

    localparam logic [63:0] ONE  = 64'h3FF0000000000000;
    localparam logic [63:0] TWO  = 64'h4000000000000000;
    localparam logic [63:0] MONE = 64'hBFF0000000000000;
    localparam logic [63:0] PZ   = 64'h0;
    localparam logic [63:0] NZ   = 64'h8000000000000000;
    localparam logic [63:0] PINF = 64'h7FF0000000000000;
    localparam logic [63:0] NINF = 64'hFFF0000000000000;
    localparam logic [63:0] QNAN = 64'h7FF8000000000000;
    localparam logic [63:0] SNAN = 64'hFFF0000000000001;

    always #10 clk = ~clk;

    fp_pred_cmp u0 (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic run(input string req, input logic [63:0] a, input logic [63:0] b,
                       input logic [2:0] p, input logic exp_t);
        @(negedge clk);
        op_a = a; op_b = b; pred = p; in_vld = 1'b1;
        @(negedge clk);
        in_vld = 1'b0;
        chk(req, mask, exp_t ? 64'hFFFFFFFFFFFFFFFF : 64'h0);
        chk({req, " vld"}, {63'd0, out_vld}, 64'd1);
    endtask

    task automatic t_reset;
        chk("R10 reset mask", mask, 64'h0);
        chk("R10 reset vld", {63'd0, out_vld}, 64'd0);
    endtask

    task automatic t_eq;
        run("R1 1==1", ONE, ONE, 3'd0, 1'b1);
        run("R1 1==2", ONE, TWO, 3'd0, 1'b0);
        run("R1 nan==nan", QNAN, QNAN, 3'd0, 1'b0);
        run("R11 snan==1", SNAN, ONE, 3'd0, 1'b0);
        run("R11 inf is not nan", PINF, PINF, 3'd0, 1'b1);
    endtask

    task automatic t_lt;
        run("R2 1<2", ONE, TWO, 3'd1, 1'b1);
        run("R2 2<1", TWO, ONE, 3'd1, 1'b0);
        run("R2 -1<1", MONE, ONE, 3'd1, 1'b1);
        run("R2 1<nan", ONE, QNAN, 3'd1, 1'b0);
        run("R2 1<=1", ONE, ONE, 3'd2, 1'b1);
        run("R2 nan<=nan", QNAN, QNAN, 3'd2, 1'b0);
        run("R2 -2<-1", TWO | NZ, MONE, 3'd1, 1'b1);
    endtask

    task automatic t_unord;
        run("R3 1,nan", ONE, QNAN, 3'd3, 1'b1);
        run("R3 1,inf", ONE, PINF, 3'd3, 1'b0);
        run("R6 1,2", ONE, TWO, 3'd7, 1'b1);
        run("R6 nan,1", QNAN, ONE, 3'd7, 1'b0);
    endtask

    task automatic t_neg;
        run("R4 1!=2", ONE, TWO, 3'd4, 1'b1);
        run("R4 inf!=inf", PINF, PINF, 3'd4, 1'b0);
        run("R4 nan!=nan", QNAN, QNAN, 3'd4, 1'b1);
        run("R5 nlt 1,2", ONE, TWO, 3'd5, 1'b0);
        run("R5 nlt 1,1", ONE, ONE, 3'd5, 1'b1);
        run("R5 nlt nan", QNAN, ONE, 3'd5, 1'b1);
        run("R5 nle 1,1", ONE, ONE, 3'd6, 1'b0);
        run("R5 nle 2,1", TWO, ONE, 3'd6, 1'b1);
        run("R5 nle 1,nan", ONE, QNAN, 3'd6, 1'b1);
    endtask

    task automatic t_inf;
        run("R8 -inf<1", NINF, ONE, 3'd1, 1'b1);
        run("R8 1<inf", ONE, PINF, 3'd1, 1'b1);
        run("R8 inf<1", PINF, ONE, 3'd1, 1'b0);
        run("R8 -inf<inf", NINF, PINF, 3'd1, 1'b1);
        run("R8 -inf==-inf", NINF, NINF, 3'd0, 1'b1);
    endtask

    task automatic t_zero;
        run("R9 +0==-0", PZ, NZ, 3'd0, 1'b1);
        run("R9 -0<+0", NZ, PZ, 3'd1, 1'b0);
        run("R9 +0<-0", PZ, NZ, 3'd1, 1'b0);
        run("R9 -0<=+0", NZ, PZ, 3'd2, 1'b1);
        run("R9 -0!=+0", NZ, PZ, 3'd4, 1'b0);
        run("R9 -0<1", NZ, ONE, 3'd1, 1'b1);
    endtask

    task automatic t_vld;
        @(negedge clk);
        in_vld = 1'b0; op_a = ONE; op_b = ONE; pred = 3'd0;
        @(negedge clk);
        chk("R10 idle vld", {63'd0, out_vld}, 64'd0);
        chk("R7 mask all ones", mask, 64'hFFFFFFFFFFFFFFFF);
    endtask

    initial begin
        #1 t_reset();
        #30 rst_n = 1'b1;
        t_eq(); t_lt(); t_unord(); t_neg(); t_inf(); t_zero(); t_vld();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule